// File: doc/BRIEF.md
# Adaptive Mesh Route and Virtual Channel Selector

This block decides, for one router of a two-dimensional mesh, which of five output directions a packet takes and which of the four virtual channels on that link it may request. The router has four neighbour directions and one local ejection direction. On a head flit the block reads the router's own coordinates and the packet's destination coordinates, and it registers a route. The route then stays in force for the body and tail flits that follow. Buffering, switch allocation and the crossbar belong to other blocks.

With no contention the packet first travels horizontally until it reaches the destination column, then travels vertically. When the packet reports that it stalled in the previous cycle and both axes still shorten its Manhattan distance, the block moves the packet to the other productive axis. When only one axis is productive, the stall leaves the choice as it is. Deadlock is avoided by reserving the highest-numbered virtual channel of a vertical link for packets that already sit in their destination column. A packet that still has horizontal hops to make may use only the lower channels of a vertical link.

Top module: `mesh_route_vc_sel`

## Requirements
- R1: While reset is high, and after it until the first head flit, `out_port` is 0 (local) and `vc_mask` is all zeros.
- R2: One clock edge after a head flit whose destination column differs from the current column, `out_port` is 1 (east, toward larger x) when the destination x is larger, and 2 (west) when it is smaller.
- R3: One clock edge after a head flit whose destination is in the current column but in another row, `out_port` is 3 (north, toward larger y) when the destination y is larger, and 4 (south) when it is smaller.
- R4: One clock edge after a head flit whose destination equals the current position, `out_port` is 0 (local) and `vc_mask` is all ones.
- R5: Whenever `out_port` is east or west, `vc_mask` is all ones.
- R6: Whenever `out_port` is north or south and the packet still has horizontal hops, `vc_mask` has its top bit (bit 3, the reserved channel) clear and all lower bits set (4'b0111).
- R7: Whenever `out_port` is north or south and the packet is in its destination column, `vc_mask` is all ones.
- R8: On a non-head cycle with the stall flag high, a packet with both horizontal and vertical hops left moves to the other axis one clock edge later. The sign toward the destination is kept, and repeated stalls alternate between the axes.
- R9: On a non-head cycle with the stall flag high, a packet with only one productive axis, or none, keeps its output port and mask.
- R10: On a non-head cycle with the stall flag low, the outputs hold their values, whatever the coordinate inputs carry.
- R11: When the head and stall flags are high together, the head flit's fresh horizontal-first route is taken and the stall is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head_vld | input | 1 | Head flit present; start a new route computation |
| stall_prev | input | 1 | The packet could not advance in the previous cycle |
| cur_x | input | X_W | Column of this router |
| cur_y | input | Y_W | Row of this router |
| dst_x | input | X_W | Destination column of the packet |
| dst_y | input | Y_W | Destination row of the packet |
| out_port | output | 3 | Selected direction: 0 local, 1 east, 2 west, 3 north, 4 south |
| vc_mask | output | NUM_VC | Virtual channels the packet may request on that direction |

## Verification
Every result is due exactly one clock edge after the cycle that carries its head or stall flag, because the route sits in one register stage and the port and mask decode from it without further delay. The bench drives inputs on the falling edge. Its behavioural model updates on the rising edge, and the bench compares the model with the outputs on the following falling edge. Hold, stall and reset behaviour are therefore checked in the very cycle they take effect, and the outputs are also compared on every cycle in between. Cycles that carry no head flag are driven with unrelated coordinates, so a route that is not held would show up at once.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;

    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_EAST  = 3'd1,
        PORT_WEST  = 3'd2,
        PORT_NORTH = 3'd3,
        PORT_SOUTH = 3'd4
    } port_e;

    // Which axes still shorten the distance, and the sign on each axis.
    typedef struct packed {
        logic need_x;
        logic need_y;
        logic go_east;
        logic go_north;
    } hop_need_t;

    function automatic logic port_is_vertical(port_e p);
        return (p == PORT_NORTH) || (p == PORT_SOUTH);
    endfunction

    function automatic logic port_is_horizontal(port_e p);
        return (p == PORT_EAST) || (p == PORT_WEST);
    endfunction

endpackage

// File: rtl/mesh_hop_eval.sv
module mesh_hop_eval
    import mesh_route_pkg::*;
#(
    parameter int X_W = 4,
    parameter int Y_W = 4
) (
    input  logic [X_W-1:0] cur_x,
    input  logic [Y_W-1:0] cur_y,
    input  logic [X_W-1:0] dst_x,
    input  logic [Y_W-1:0] dst_y,
    output hop_need_t      need
);
    always_comb begin
        need.need_x   = (cur_x != dst_x);
        need.need_y   = (cur_y != dst_y);
        need.go_east  = (dst_x > cur_x);
        need.go_north = (dst_y > cur_y);
    end
endmodule

// File: rtl/mesh_route_state.sv
module mesh_route_state
    import mesh_route_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      head_i,
    input  logic      stall_i,
    input  hop_need_t need_i,
    output hop_need_t held_o,
    output logic      vert_o,
    output logic      live_o
);
    hop_need_t held_q;
    logic      vert_q;
    logic      live_q;
    logic      both_axes;

    assign both_axes = held_q.need_x && held_q.need_y;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            vert_q <= 1'b0;
            live_q <= 1'b0;
        end else if (head_i) begin
            held_q <= need_i;
            vert_q <= !need_i.need_x && need_i.need_y;
            live_q <= 1'b1;
        end else if (stall_i && both_axes) begin
            vert_q <= !vert_q;
        end
    end

    assign held_o = held_q;
    assign vert_o = vert_q;
    assign live_o = live_q;

    // R8: a stall with two productive axes swaps the axis
    a_r8_axis_flip: assert property (@(posedge clk) disable iff (rst)
        (!head_i && stall_i && both_axes) |=> (vert_q != $past(vert_q)));

    // R9: a stall with at most one productive axis keeps the axis
    a_r9_axis_keep: assert property (@(posedge clk) disable iff (rst)
        (!head_i && stall_i && !both_axes) |=> $stable(vert_q));

    // R10: no head and no stall leaves the route untouched
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!head_i && !stall_i) |=> ($stable(vert_q) && $stable(held_q) && $stable(live_q)));

    // R11: a head flit starts on the horizontal axis whenever it has columns to cross
    a_r11_head_wins: assert property (@(posedge clk) disable iff (rst)
        (head_i && need_i.need_x) |=> !vert_q);
endmodule

// File: rtl/mesh_port_mask.sv
module mesh_port_mask
    import mesh_route_pkg::*;
#(
    parameter int NUM_VC = 4
) (
    input  hop_need_t         held_i,
    input  logic              vert_i,
    input  logic              live_i,
    output port_e             port_o,
    output logic [NUM_VC-1:0] mask_o
);
    localparam int ESC_VC = NUM_VC - 1;

    logic at_dest;
    logic restrict_esc;

    assign at_dest      = !held_i.need_x && !held_i.need_y;
    assign restrict_esc = live_i && !at_dest && vert_i && held_i.need_x;

    always_comb begin
        if (!live_i || at_dest)
            port_o = PORT_LOCAL;
        else if (vert_i)
            port_o = held_i.go_north ? PORT_NORTH : PORT_SOUTH;
        else
            port_o = held_i.go_east ? PORT_EAST : PORT_WEST;
    end

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        if (v == ESC_VC) begin : g_esc
            assign mask_o[v] = live_i && !restrict_esc;
        end else begin : g_norm
            assign mask_o[v] = live_i;
        end
    end
endmodule

// File: rtl/mesh_route_vc_sel.sv
module mesh_route_vc_sel
    import mesh_route_pkg::*;
#(
    parameter int X_W    = 4,
    parameter int Y_W    = 4,
    parameter int NUM_VC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              head_vld,
    input  logic              stall_prev,
    input  logic [X_W-1:0]    cur_x,
    input  logic [Y_W-1:0]    cur_y,
    input  logic [X_W-1:0]    dst_x,
    input  logic [Y_W-1:0]    dst_y,
    output logic [2:0]        out_port,
    output logic [NUM_VC-1:0] vc_mask
);
    hop_need_t need_now;
    hop_need_t need_held;
    logic      vert_sel;
    logic      route_live;
    port_e     port_sel;

    mesh_hop_eval #(.X_W(X_W), .Y_W(Y_W)) u_eval (
        .cur_x (cur_x),
        .cur_y (cur_y),
        .dst_x (dst_x),
        .dst_y (dst_y),
        .need  (need_now)
    );

    mesh_route_state u_state (
        .clk     (clk),
        .rst     (rst),
        .head_i  (head_vld),
        .stall_i (stall_prev),
        .need_i  (need_now),
        .held_o  (need_held),
        .vert_o  (vert_sel),
        .live_o  (route_live)
    );

    mesh_port_mask #(.NUM_VC(NUM_VC)) u_mask (
        .held_i (need_held),
        .vert_i (vert_sel),
        .live_i (route_live),
        .port_o (port_sel),
        .mask_o (vc_mask)
    );

    assign out_port = port_sel;

    // R1: in reset no channel is offered and the port is local
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (out_port == 3'd0 && vc_mask == '0));

    // R2: horizontal-first on a head flit with columns to cross
    a_r2_x_first: assert property (@(posedge clk) disable iff (rst)
        (head_vld && cur_x != dst_x) |=> port_is_horizontal(port_sel));

    // R4: arrival ejects locally with every channel
    a_r4_eject: assert property (@(posedge clk) disable iff (rst)
        (head_vld && cur_x == dst_x && cur_y == dst_y) |=> (out_port == 3'd0 && &vc_mask));

    // R5: horizontal links never restrict channels
    a_r5_x_all_vc: assert property (@(posedge clk) disable iff (rst)
        port_is_horizontal(port_sel) |-> &vc_mask);

    // R6: the reserved vertical channel is granted only in the destination column
    a_r6_escape_reserved: assert property (@(posedge clk) disable iff (rst)
        (port_is_vertical(port_sel) && vc_mask[NUM_VC-1]) |-> !need_held.need_x);
endmodule

// File: tb/mesh_route_vc_sel_bench.sv
module mesh_route_vc_sel_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       head_vld, stall_prev;
    logic [3:0] cur_x, cur_y, dst_x, dst_y;
    logic [2:0] out_port;
    logic [3:0] vc_mask;

    always #2 clk = ~clk; // 250 MHz

    mesh_route_vc_sel u_mesh_route_vc_sel (
        .clk(clk), .rst(rst), .head_vld(head_vld), .stall_prev(stall_prev),
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
        .out_port(out_port), .vc_mask(vc_mask)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit m_live, m_nx, m_ny, m_e, m_n, m_vert;

    always @(posedge clk) begin
        if (rst) begin
            m_live = 0; m_nx = 0; m_ny = 0; m_e = 0; m_n = 0; m_vert = 0;
        end else if (head_vld) begin
            m_live = 1;
            m_nx   = (int'(cur_x) != int'(dst_x));
            m_ny   = (int'(cur_y) != int'(dst_y));
            m_e    = (int'(dst_x) > int'(cur_x));
            m_n    = (int'(dst_y) > int'(cur_y));
            m_vert = !m_nx && m_ny;
        end else if (stall_prev && m_nx && m_ny) begin
            m_vert = !m_vert;
        end
    end

    task automatic compare();
        int ep, em;
        if (!m_live) begin ep = 0; em = 0; end
        else if (!m_nx && !m_ny) begin ep = 0; em = 15; end
        else if (m_vert) begin ep = m_n ? 3 : 4; em = m_nx ? 7 : 15; end
        else begin ep = m_e ? 1 : 2; em = 15; end
        n_vec++;
        if (int'(out_port) != ep || int'(vc_mask) != em) begin
            n_bad++;
            $display("FAIL %s: port=%0d mask=%b, expected port=%0d mask=%b",
                     cur_req, out_port, vc_mask, ep, em[3:0]);
        end
    endtask

    task automatic step(input bit h, input bit s,
                        input int cx, input int cy, input int dx, input int dy);
        @(negedge clk);
        compare();
        head_vld = h; stall_prev = s;
        cur_x = 4'(cx); cur_y = 4'(cy); dst_x = 4'(dx); dst_y = 4'(dy);
    endtask

    // non-head cycle with scrambled coordinates (R10)
    task automatic idle(input bit s);
        step(0, s, $urandom_range(15), $urandom_range(15),
                   $urandom_range(15), $urandom_range(15));
    endtask

    initial begin
        rst = 1; head_vld = 0; stall_prev = 0;
        cur_x = 0; cur_y = 0; dst_x = 0; dst_y = 0;
        cur_req = "R1";
        repeat (3) step(1, 0, 1, 1, 5, 5);   // head during reset must not take
        @(negedge clk); rst = 0;
        repeat (2) idle(0);                    // still idle after reset (R1)

        cur_req = "R2";                        // east, then hold (R5)
        step(1, 0, 2, 2, 9, 2);
        cur_req = "R10"; repeat (4) idle(0);
        cur_req = "R2";  step(1, 0, 9, 3, 1, 3); // west
        cur_req = "R5";  repeat (2) idle(0);

        cur_req = "R3";  step(1, 0, 4, 4, 4, 12); // north, same column
        cur_req = "R7";  repeat (2) idle(0);
        cur_req = "R3";  step(1, 0, 4, 9, 4, 1);  // south
        cur_req = "R9";  repeat (3) idle(1);      // only one axis: stall ignored

        cur_req = "R4";  step(1, 0, 6, 6, 6, 6);
        cur_req = "R9";  repeat (2) idle(1);

        cur_req = "R8";  step(1, 0, 1, 1, 7, 8);  // both axes: east first
        repeat (5) idle(1);                       // alternates N / E
        cur_req = "R6";  step(0, 1, 0, 0, 0, 0);  // now north with x pending
        idle(0); idle(0);
        cur_req = "R8";  step(1, 0, 10, 10, 3, 2); // west/south pair
        idle(1); idle(0); idle(1); idle(0);

        cur_req = "R11"; step(1, 0, 1, 1, 7, 8);
        idle(1);                                   // now vertical
        step(1, 1, 0, 0, 5, 9);                    // head+stall: fresh east
        idle(0); idle(0);

        cur_req = "R10";
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(3) == 0)
                step(1, 1'($urandom_range(1)), $urandom_range(15), $urandom_range(15),
                     $urandom_range(15), $urandom_range(15));
            else
                idle(1'($urandom_range(1)));
        end
        cur_req = "R1";
        step(0, 0, 0, 0, 0, 0);
        rst = 1;
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule